// File: doc/BRIEF.md
# ATM Cell Header Error Screen

This block sits on the receive side of a cell link, after cell boundaries have already been found. It takes a stream of 53-octet cells, one octet per valid beat, with a start-of-cell flag on the first header octet. For each cell it checks the four address/control octets against the fifth (check) octet. The check octet uses an 8-bit cyclic code with generator x^8+x^2+x+1 and a fixed 01010101 offset. Based on that result, the block either forwards the cell unchanged, repairs a single flipped header bit and forwards the cell, or suppresses the whole cell.

A two-state mode machine controls the repair. In the repair-allowed state, one repair is permitted, after which the machine moves to a strict state. In the strict state, every errored header is thrown away, including ones a single flip could fix. The first clean header returns the machine to the repair-allowed state. Every octet is delayed by a five-beat line. This lets the header verdict reach the header octets and the rest of the cell before any of them leave.

Two saturating event counters, one for repaired cells and one for discarded cells, are provided. A one-cycle discard strobe marks each discarded cell.

Top module: `hec_cell_screen`

## Requirements
- R1: After reset the block is in the repair-allowed state, both counters read zero, and out_valid is low.
- R2: The check octet is the CRC of header octets 1 to 4, taken most significant bit first, with generator 0x07 and the register preset to zero, XORed with 0x55. A header that matches is forwarded unchanged and changes neither counter nor the state.
- R3: In the repair-allowed state, a header whose syndrome matches the pattern of exactly one of its 40 bits is forwarded with that bit inverted. fixed_count then increments and the block enters the strict state.
- R4: In the repair-allowed state, a header with a nonzero syndrome that matches no single-bit pattern causes the whole cell to be suppressed. drop_count then increments and the block enters the strict state.
- R5: In the strict state, any header with a nonzero syndrome causes its cell to be suppressed and drop_count to increment. This includes single-bit errors, and the block stays in the strict state.
- R6: In the strict state, a clean header is forwarded and returns the block to the repair-allowed state.
- R7: A forwarded octet appears on out_data with out_valid high in the clock cycle after the input beat that carries the fifth later octet. The delay is counted in valid input beats only, so gaps in in_valid stall the line and produce no output. out_sop is high only on header octet 1.
- R8: A high in_sop always restarts the header count. A cell whose header is cut short by a new in_sop produces no output octets, and neither do octets received before the first in_sop.
- R9: drop_pulse is high for exactly one cycle per suppressed cell, in the cycle after the fifth header octet is accepted.
- R10: Each counter stops at its all-ones value and holds there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input octet is present this cycle |
| in_sop | input | 1 | Input octet is the first header octet of a cell |
| in_data | input | 8 | Input octet |
| out_valid | output | 1 | Forwarded octet is present this cycle |
| out_sop | output | 1 | Forwarded octet is the first header octet |
| out_data | output | 8 | Forwarded octet, header repaired when required |
| drop_pulse | output | 1 | One-cycle strobe per suppressed cell |
| fixed_count | output | CNT_W | Saturating count of repaired cells |
| drop_count | output | CNT_W | Saturating count of suppressed cells |

## Verification
The bench walks a sequence of cells that moves the mode machine through every transition. Each transition is exercised more than once, including a single-bit error that arrives in the strict state. A design that repaired it would emit a cell that should vanish. A design that never left the repair-allowed state would keep repairing and under-count discards.

Errors are placed on the top data bit, the lowest data bit and a check-octet bit. A wrongly ordered syndrome table would then forward a header with the wrong bit inverted.

Directed tests cover four more cases:
- The exact output latency and stall on gaps. An off-by-one delay line shifts every octet by a beat.
- A cell cut short by a new start flag. Leaking its octets would show up as unexpected output.
- Counters built narrow, so that they must saturate rather than wrap to zero.
- Reset taken from the strict state, which must come back allowing one repair.

// File: rtl/hec_pkg.sv
// Shared constants, types and the header check code arithmetic.
// Assumes a 5-octet header: 32 protected bits followed by an 8-bit check octet.
package hec_pkg;

    localparam int HDR_OCTETS = 5;
    localparam int HDR_BITS   = HDR_OCTETS * 8;
    localparam int BODY_BITS  = HDR_BITS - 8;
    localparam logic [7:0] GEN_POLY = 8'h07;
    localparam logic [7:0] COSET    = 8'h55;

    typedef enum logic {
        MODE_REPAIR = 1'b0,
        MODE_STRICT = 1'b1
    } chk_mode_e;

    typedef struct packed {
        logic clean;
        logic single;
        logic multi;
    } verdict_t;

    // Serial CRC over the protected bits, MSB first, register preset to zero.
    function automatic logic [7:0] crc8_body(input logic [BODY_BITS-1:0] w);
        logic [7:0] r;
        logic       fb;
        r = '0;
        for (int i = BODY_BITS - 1; i >= 0; i--) begin
            fb = r[7] ^ w[i];
            r  = {r[6:0], 1'b0} ^ (fb ? GEN_POLY : 8'h00);
        end
        return r;
    endfunction

    // Syndrome produced by an error in header bit pos (0 = LSB of check octet).
    function automatic logic [7:0] flip_signature(input int pos);
        logic [BODY_BITS-1:0] w;
        if (pos < 8) begin
            return 8'(1) << pos;
        end
        w = '0;
        w[pos-8] = 1'b1;
        return crc8_body(w);
    endfunction

endpackage

// File: rtl/hec_syndrome.sv
// Computes the header syndrome and classifies it.
// Purely combinational; the caller presents a full 40-bit header.
// Output flip_mask marks the single bit to invert when verdict.single is set.
module hec_syndrome
    import hec_pkg::*;
(
    input  logic [HDR_BITS-1:0] hdr_in,
    output verdict_t            verdict,
    output logic [HDR_BITS-1:0] flip_mask
);

    logic [7:0] syn;

    // Remove the coset from the received check octet and compare with the CRC.
    always_comb syn = crc8_body(hdr_in[HDR_BITS-1:8]) ^ hdr_in[7:0] ^ COSET;

    // One comparator per header bit against its precomputed error signature.
    for (genvar j = 0; j < HDR_BITS; j++) begin : g_pos
        localparam logic [7:0] SIG = flip_signature(j);
        assign flip_mask[j] = (syn == SIG);
    end

    // Sort the syndrome into clean / single / multi.
    always_comb begin
        verdict.clean  = (syn == 8'h00);
        verdict.single = |flip_mask;
        verdict.multi  = !verdict.clean && !verdict.single;
    end

endmodule

// File: rtl/hec_mode_fsm.sv
// Two-state repair policy. Evaluates on decide (header complete).
// Assumes verdict is valid whenever decide is high; outputs are combinational.
module hec_mode_fsm
    import hec_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      decide,
    input  verdict_t  verdict,
    output logic      pass_cell,
    output logic      apply_fix,
    output logic      drop_cell,
    output chk_mode_e mode
);

    chk_mode_e nxt;

    // Policy and next-state decode for the current header.
    always_comb begin
        unique case (mode)
            MODE_REPAIR: begin
                pass_cell = !verdict.multi;
                apply_fix = verdict.single;
                nxt       = verdict.clean ? MODE_REPAIR : MODE_STRICT;
            end
            default: begin
                pass_cell = verdict.clean;
                apply_fix = 1'b0;
                nxt       = verdict.clean ? MODE_REPAIR : MODE_STRICT;
            end
        endcase
        drop_cell = !pass_cell;
    end

    // Mode register, updated once per header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_REPAIR;
        end else if (decide) begin
            mode <= nxt;
        end
    end

    p_reset_repair_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> mode == MODE_REPAIR);

    p_fix_goes_strict_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && mode == MODE_REPAIR && verdict.single) |=> mode == MODE_STRICT);

    p_multi_goes_strict_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && mode == MODE_REPAIR && verdict.multi) |=> mode == MODE_STRICT);

    p_strict_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && mode == MODE_STRICT && !verdict.clean) |=> mode == MODE_STRICT);

    p_clean_restores_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && verdict.clean) |=> mode == MODE_REPAIR);

endmodule

// File: rtl/hec_sat_counter.sv
// Saturating event counter; increments on bump and holds at all-ones.
module hec_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bump,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] TOP = '1;

    // Count events until the ceiling is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (bump && cnt != TOP) begin
            cnt <= cnt + W'(1);
        end
    end

    p_count_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == TOP) |=> cnt == TOP);

    p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bump && cnt != TOP) |=> cnt == $past(cnt) + W'(1));

endmodule

// File: rtl/hec_cell_screen.sv
// Receive-side header check and repair for header-aligned 53-octet cells.
// Assumes cell boundaries are already known (in_sop on header octet 1).
// Every octet passes a HDR_OCTETS-deep line advanced on valid beats, so the
// header verdict is known before any octet of the cell leaves.
module hec_cell_screen
    import hec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [7:0]       in_data,
    output logic             out_valid,
    output logic             out_sop,
    output logic [7:0]       out_data,
    output logic             drop_pulse,
    output logic [CNT_W-1:0] fixed_count,
    output logic [CNT_W-1:0] drop_count
);

    localparam int DEPTH = HDR_OCTETS;
    localparam int IDX_W = $clog2(HDR_OCTETS + 1);
    localparam logic [IDX_W-1:0] IDX_PAYLOAD = IDX_W'(HDR_OCTETS);
    localparam logic [IDX_W-1:0] IDX_LAST    = IDX_W'(HDR_OCTETS - 1);

    logic [IDX_W-1:0]     oct_idx;
    logic [IDX_W-1:0]     cur_idx;
    logic                 hdr_beat;
    logic                 decide;
    logic [BODY_BITS-1:0] hdr_sr;
    logic [HDR_BITS-1:0]  hdr_full;
    logic [HDR_BITS-1:0]  hdr_fixed;
    logic [HDR_BITS-1:0]  flip_mask;
    verdict_t             verdict;
    logic                 pass_cell;
    logic                 apply_fix;
    logic                 drop_cell;
    chk_mode_e            mode;
    logic                 cell_keep;

    logic [7:0] slot_d    [DEPTH];
    logic       slot_v    [DEPTH];
    logic       slot_sop  [DEPTH];
    logic       slot_keep [DEPTH];

    // Position of the current beat within the cell and header completion.
    always_comb begin
        cur_idx   = in_sop ? '0 : oct_idx;
        hdr_beat  = in_valid && (cur_idx < IDX_PAYLOAD);
        decide    = in_valid && (cur_idx == IDX_LAST);
        hdr_full  = {hdr_sr, in_data};
        hdr_fixed = apply_fix ? (hdr_full ^ flip_mask) : hdr_full;
    end

    // Octet index; starts saturated so data before the first in_sop is payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oct_idx <= IDX_PAYLOAD;
        end else if (hdr_beat) begin
            oct_idx <= cur_idx + IDX_W'(1);
        end
    end

    // Collect the protected header octets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_sr <= '0;
        end else if (hdr_beat) begin
            hdr_sr <= {hdr_sr[BODY_BITS-9:0], in_data};
        end
    end

    // Keep decision for payload octets of the current cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_keep <= 1'b0;
        end else if (decide) begin
            cell_keep <= pass_cell;
        end else if (in_valid && in_sop) begin
            cell_keep <= 1'b0;
        end
    end

    hec_syndrome u_syn (
        .hdr_in    (hdr_full),
        .verdict   (verdict),
        .flip_mask (flip_mask)
    );

    hec_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .decide    (decide),
        .verdict   (verdict),
        .pass_cell (pass_cell),
        .apply_fix (apply_fix),
        .drop_cell (drop_cell),
        .mode      (mode)
    );

    // Delay line; on the header's last octet rewrite all header slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot_d[i]    <= '0;
                slot_v[i]    <= 1'b0;
                slot_sop[i]  <= 1'b0;
                slot_keep[i] <= 1'b0;
            end
        end else if (in_valid) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                slot_d[i]    <= slot_d[i+1];
                slot_v[i]    <= slot_v[i+1];
                slot_sop[i]  <= slot_sop[i+1];
                slot_keep[i] <= slot_keep[i+1];
            end
            slot_d[DEPTH-1]    <= in_data;
            slot_v[DEPTH-1]    <= 1'b1;
            slot_sop[DEPTH-1]  <= in_sop;
            slot_keep[DEPTH-1] <= hdr_beat ? 1'b0 : cell_keep;
            if (decide) begin
                for (int i = 0; i < DEPTH; i++) begin
                    slot_d[i]    <= hdr_fixed[HDR_BITS-1-8*i -: 8];
                    slot_keep[i] <= pass_cell;
                end
            end
        end
    end

    // Output register: the oldest slot leaves when a new octet enters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sop    <= 1'b0;
            out_data   <= '0;
            drop_pulse <= 1'b0;
        end else begin
            out_valid  <= in_valid && slot_v[0] && slot_keep[0];
            out_sop    <= in_valid && slot_v[0] && slot_keep[0] && slot_sop[0];
            out_data   <= slot_d[0];
            drop_pulse <= decide && drop_cell;
        end
    end

    hec_sat_counter #(.W(CNT_W)) u_fix_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (decide && apply_fix),
        .cnt   (fixed_count)
    );

    hec_sat_counter #(.W(CNT_W)) u_drop_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (decide && drop_cell),
        .cnt   (drop_count)
    );

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fixed_count == '0 && drop_count == '0 && !out_valid));

    p_one_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> $onehot0(flip_mask));

    p_strict_discards_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && mode == MODE_STRICT && !verdict.clean) |=> (drop_pulse && $stable(fixed_count)));

    p_sop_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> out_valid);

    p_no_output_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_drop_single_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |=> !drop_pulse);

endmodule

// File: tb/sim_hec_cell_screen.sv
// Bench: vector table walked by one loop, then directed reset/corner tests.
module sim_hec_cell_screen;

    localparam int CLK_PERIOD  = 10;
    localparam int CW          = 2;
    localparam int SAT         = (1 << CW) - 1;
    localparam int CELL_OCTETS = 53;
    localparam int NVEC        = 16;

    typedef struct packed {
        logic [31:0] hdr;
        logic [39:0] emask;
        logic        keep;
        logic        fix;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0001, 40'h00_0000_0000, 1'b1, 1'b0},
        '{32'h0123_4567, 40'h80_0000_0000, 1'b1, 1'b1},
        '{32'h89AB_CDEF, 40'h00_0000_0008, 1'b0, 1'b0},
        '{32'h1357_9BDF, 40'h00_0000_0000, 1'b1, 1'b0},
        '{32'h2468_ACE0, 40'h00_0000_0C00, 1'b0, 1'b0},
        '{32'hFFFF_FFF0, 40'h00_0000_0000, 1'b1, 1'b0},
        '{32'h0F0F_0F0F, 40'h00_0010_0000, 1'b1, 1'b1},
        '{32'h5555_AAAA, 40'h00_0000_0001, 1'b0, 1'b0},
        '{32'h3C3C_C3C3, 40'h00_4002_0002, 1'b0, 1'b0},
        '{32'h0000_0010, 40'h00_0000_0000, 1'b1, 1'b0},
        '{32'h7E00_0042, 40'h00_0000_0000, 1'b1, 1'b0},
        '{32'hDEAD_BEEF, 40'h00_0000_0100, 1'b1, 1'b1},
        '{32'h0101_0101, 40'h00_0000_0000, 1'b1, 1'b0},
        '{32'hA5A5_5A5A, 40'h10_0000_0010, 1'b0, 1'b0},
        '{32'h0000_0000, 40'h00_0000_0000, 1'b1, 1'b0},
        '{32'h6B6B_1234, 40'h00_8000_0000, 1'b1, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sop = 1'b0;
    logic [7:0]    in_data = 8'h00;
    logic          out_valid;
    logic          out_sop;
    logic [7:0]    out_data;
    logic          drop_pulse;
    logic [CW-1:0] fixed_count;
    logic [CW-1:0] drop_count;

    int   checks = 0;
    int   fails = 0;
    int   exp_wr = 0;
    int   exp_rd = 0;
    int   drops_seen = 0;
    logic mon_on = 1'b0;
    logic [8:0] exp_q [0:2047];

    always #(CLK_PERIOD / 2) clk = ~clk;

    hec_cell_screen #(.CNT_W(CW)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_sop      (in_sop),
        .in_data     (in_data),
        .out_valid   (out_valid),
        .out_sop     (out_sop),
        .out_data    (out_data),
        .drop_pulse  (drop_pulse),
        .fixed_count (fixed_count),
        .drop_count  (drop_count)
    );

    function automatic logic [7:0] ref_crc(input logic [31:0] w);
        logic [7:0] r;
        logic       fb;
        r = 8'h00;
        for (int i = 31; i >= 0; i--) begin
            fb = r[7] ^ w[i];
            r  = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return r;
    endfunction

    function automatic logic [39:0] make_hdr(input logic [31:0] h);
        return {h, ref_crc(h) ^ 8'h55};
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic put(input logic [7:0] b, input logic sop);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        in_sop   = sop;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_sop   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_cell(input logic [39:0] tx, input logic [39:0] clean,
                             input logic push, input int seed, input logic gaps);
        for (int k = 0; k < CELL_OCTETS; k++) begin
            logic [7:0] b;
            logic [7:0] e;
            b = (k < 5) ? tx[39-8*k -: 8] : 8'((seed * 7 + k) & 8'hFF);
            e = (k < 5) ? clean[39-8*k -: 8] : b;
            put(b, k == 0);
            if (push) begin
                exp_q[exp_wr] = {k == 0, e};
                exp_wr++;
            end
            if (gaps && (k % 11 == 10)) idle();
        end
    endtask

    // Output scoreboard: every forwarded octet must match the next expected one (R7).
    always @(negedge clk) begin
        if (mon_on && rst_n && out_valid) begin
            checks++;
            if (exp_rd >= exp_wr) begin
                fails++;
                $display("FAIL R8 got %0h expected no output", {out_sop, out_data});
            end else begin
                if ({out_sop, out_data} !== exp_q[exp_rd]) begin
                    fails++;
                    $display("FAIL R7 got %0h expected %0h", {out_sop, out_data}, exp_q[exp_rd]);
                end
                exp_rd++;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && drop_pulse) drops_seen++;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int   m_fix;
        int   m_drop;
        logic strict;
        string tag;
        m_fix  = 0;
        m_drop = 0;
        strict = 1'b0;

        do_reset();
        check("R1 out_valid", out_valid, 1'b0);
        check("R1 fixed_count", fixed_count, 0);
        check("R1 drop_count", drop_count, 0);

        mon_on = 1'b1;
        for (int v = 0; v < NVEC; v++) begin
            logic [39:0] clean;
            clean = make_hdr(VECS[v].hdr);
            if (VECS[v].fix)        tag = "R3";
            else if (!VECS[v].keep) tag = strict ? "R5" : "R4";
            else                    tag = strict ? "R6" : "R2";
            send_cell(clean ^ VECS[v].emask, clean, VECS[v].keep, v, v[0]);
            if (VECS[v].fix) m_fix++;
            if (!VECS[v].keep) m_drop++;
            strict = !(VECS[v].keep && !VECS[v].fix);
            check({tag, " R10 fixed_count"}, fixed_count, (m_fix > SAT) ? SAT : m_fix);
            check({tag, " R10 drop_count"}, drop_count, (m_drop > SAT) ? SAT : m_drop);
            check({tag, " R9 drop pulses"}, drops_seen, m_drop);
        end

        // R8: header cut short by a new start flag, then a clean cell.
        put(8'hAA, 1'b1);
        put(8'hBB, 1'b0);
        put(8'hCC, 1'b0);
        send_cell(make_hdr(32'h7777_0000), make_hdr(32'h7777_0000), 1'b1, 40, 1'b0);
        for (int k = 0; k < 5; k++) put(make_hdr(32'h0)[39-8*k -: 8], k == 0);
        idle();
        repeat (4) @(negedge clk);
        check("R7 all kept octets delivered", exp_rd, exp_wr);
        check("R8 drop_count unchanged", drops_seen, m_drop);
        mon_on = 1'b0;

        // R1: reset clears counters that had been nonzero.
        do_reset();
        check("R1 out_valid after reset", out_valid, 1'b0);
        check("R1 fixed_count after reset", fixed_count, 0);
        check("R1 drop_count after reset", drop_count, 0);

        // R7: exact latency and stall on a gap.
        begin
            logic [39:0] h;
            h = make_hdr(32'h0ABC_DEF0);
            for (int k = 0; k < 5; k++) put(h[39-8*k -: 8], k == 0);
            put(8'h5A, 1'b0);
            check("R7 no output before sixth beat", out_valid, 1'b0);
            idle();
            check("R7 first octet valid", out_valid, 1'b1);
            check("R7 first octet data", out_data, h[39:32]);
            check("R7 first octet sop", out_sop, 1'b1);
            idle();
            check("R7 stall on gap", out_valid, 1'b0);
        end

        // R9/R4: double error in repair state, pulse timing and width.
        begin
            logic [39:0] h;
            h = make_hdr(32'h1111_2222) ^ 40'h00_0000_0C00;
            for (int k = 0; k < 5; k++) put(h[39-8*k -: 8], k == 0);
            idle();
            check("R9 drop_pulse after fifth octet", drop_pulse, 1'b1);
            check("R4 drop_count", drop_count, 1);
            idle();
            check("R9 drop_pulse one cycle", drop_pulse, 1'b0);
        end

        // R1: reset from strict state must again allow one repair; R5 then drops.
        do_reset();
        begin
            logic [39:0] h;
            h = make_hdr(32'h4242_4242) ^ 40'h00_0000_0020;
            for (int k = 0; k < 5; k++) put(h[39-8*k -: 8], k == 0);
            idle();
            check("R1 repair allowed after reset", fixed_count, 1);
            check("R1 no drop after reset", drop_count, 0);
            for (int k = 0; k < 5; k++) put(h[39-8*k -: 8], k == 0);
            idle();
            check("R5 single error dropped in strict", drop_count, 1);
            check("R5 no second repair", fixed_count, 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule